// File: doc/BRIEF.md
# SONET Framing Aligner and Deserializer

This block takes a recovered serial bit stream, one bit per cycle in which `bit_vld` is high, and turns it into 8-bit words with a one-cycle byte strobe. While the downstream framer holds `search_en` high, the block looks for the 48-bit SONET framing sequence at every bit position. The sequence is three 0xF6 bytes followed by three 0x28 bytes. When the sequence is found, the block moves its byte boundary onto it. It also raises a frame pulse together with the word that carries the final 0x28 byte.

A small two-state mode controller follows `search_en`. In MODE_HOLD the boundary stays where it was last placed and no frame pulse is produced. In MODE_HUNT every match realigns the boundary and fires the pulse again. There are two transitions. HOLD to HUNT is taken at the clock after `search_en` is seen high. HUNT to HOLD is taken at the clock after it is seen low. Reset forces MODE_HOLD.

Top module: `sonet_frame_aligner`

## Requirements
- R1: A synchronous active-high `rst` clears the bit counter and the 48-bit history, drives `byte_vld`, `frame_pulse` and `byte_out` to 0, and places the boundary so that the first byte completes on the eighth valid bit after reset.
- R2: While hunting, a detection occurs on the valid bit that completes any 48-bit window equal to 0xF6F6F6282828 (first received bit = window MSB), whatever its bit offset.
- R3: `search_en` is registered into the mode state, so it takes effect from the clock after it is sampled. With the mode in HOLD, the pattern produces no detection.
- R4: A detection ends a byte on that same bit: the word 0x28 is strobed immediately, any partly assembled byte is dropped, and the next word is built from the following eight valid bits. When a detection coincides with a natural byte end, exactly one strobe is produced.
- R5: `frame_pulse` rises in the same cycle as the `byte_vld` of the word holding the third 0x28 byte, and does so again for every later detection while hunting.
- R6: `frame_pulse` is updated only when a word is strobed: it stays high until the next `byte_vld`, which clears it unless that word is itself a detection.
- R7: In HOLD no detection occurs, no frame pulse is generated, and words keep completing every eight valid bits from the last boundary found.
- R8: A cycle with `bit_vld` low advances nothing: no strobe follows it and the byte phase is unchanged.
- R9: Words are assembled MSB first, with the earliest of the eight bits on `byte_out[7]`, and a strobe appears once every eight valid bits in the absence of detections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial data bit |
| search_en | input | 1 | High requests framing pattern search (out of frame) |
| byte_out | output | 8 | Assembled word, valid with `byte_vld` |
| byte_vld | output | 1 | One-cycle strobe for each completed word |
| frame_pulse | output | 1 | Frame boundary marker, held from its word's strobe to the next strobe |

## Verification
Two events can land on the same bit: a natural byte completion from the counter and a pattern detection that forces realignment. The bench sweeps the pattern over all eight bit offsets from the reset boundary. Offset zero makes the final 0x28 bit fall exactly on a counter wrap. For every offset, the bench counts strobes across the filler and the pattern and compares the total with floor((offset+47)/8)+1. A doubled strobe or a missed realignment changes that count, as does a pulse on the wrong word.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_HUNT = 1'b1
    } sfa_mode_e;
endpackage

// File: rtl/sfa_mode_ctrl.sv
module sfa_mode_ctrl
    import sfa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic search_req,
    output logic hunt
);
    sfa_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD: if (search_req)  state_d = MODE_HUNT;
            MODE_HUNT: if (!search_req) state_d = MODE_HOLD;
            default:                    state_d = MODE_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        hunt = (state_q == MODE_HUNT);
    end

    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        search_req |=> hunt); // R3
    AST_MODE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !search_req |=> !hunt); // R7
endmodule

// File: rtl/sfa_pattern_win.sv
module sfa_pattern_win #(
    parameter int          WORD_W = 8,
    parameter int          REP    = 3,
    parameter logic [7:0]  SYNC_HI = 8'hF6,
    parameter logic [7:0]  SYNC_LO = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              hunt,
    output logic              match,
    output logic [WORD_W-1:0] tail
);
    localparam int PAT_W = 2 * REP * WORD_W;

    function automatic logic [PAT_W-1:0] build_pat();
        logic [PAT_W-1:0] p;
        p = '0;
        for (int i = 0; i < 2 * REP; i++) begin
            p[PAT_W-1-i*WORD_W -: WORD_W] = (i < REP) ? WORD_W'(SYNC_HI) : WORD_W'(SYNC_LO);
        end
        return p;
    endfunction

    localparam logic [PAT_W-1:0] PATTERN = build_pat();

    logic [PAT_W-1:0] win_q;
    logic [PAT_W-1:0] win_d;

    always_comb begin
        win_d = {win_q[PAT_W-2:0], bit_in};
        tail  = win_d[WORD_W-1:0];
        match = hunt && bit_vld && (win_d == PATTERN);
    end

    always_ff @(posedge clk) begin
        if (rst)          win_q <= '0;
        else if (bit_vld) win_q <= win_d;
    end

    AST_WIN_STALL: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(win_q)); // R8
    AST_MATCH_TAIL: assert property (@(posedge clk) disable iff (rst)
        match |-> (tail == WORD_W'(SYNC_LO))); // R2
endmodule

// File: rtl/sfa_byte_asm.sv
module sfa_byte_asm #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              match,
    input  logic [WORD_W-1:0] tail,
    output logic [WORD_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_pulse
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done;

    always_comb begin
        done = bit_vld && (match || (cnt_q == LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            byte_out    <= '0;
            byte_vld    <= 1'b0;
            frame_pulse <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (done) begin
                cnt_q       <= '0;
                byte_out    <= tail;
                byte_vld    <= 1'b1;
                frame_pulse <= match;
            end else if (bit_vld) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_STALL_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> !byte_vld); // R8
    AST_STALL_PHASE: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(cnt_q)); // R8
    AST_PULSE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> byte_vld); // R5
    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |-> $stable(frame_pulse)); // R6
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
    parameter int         WORD_W  = 8,
    parameter int         REP     = 3,
    parameter logic [7:0] SYNC_HI = 8'hF6,
    parameter logic [7:0] SYNC_LO = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              search_en,
    output logic [WORD_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_pulse
);
    logic              hunt;
    logic              match;
    logic [WORD_W-1:0] tail;

    sfa_mode_ctrl i_mode (
        .clk        (clk),
        .rst        (rst),
        .search_req (search_en),
        .hunt       (hunt)
    );

    sfa_pattern_win #(
        .WORD_W  (WORD_W),
        .REP     (REP),
        .SYNC_HI (SYNC_HI),
        .SYNC_LO (SYNC_LO)
    ) i_win (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .hunt    (hunt),
        .match   (match),
        .tail    (tail)
    );

    sfa_byte_asm #(
        .WORD_W (WORD_W)
    ) i_asm (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (bit_vld),
        .match       (match),
        .tail        (tail),
        .byte_out    (byte_out),
        .byte_vld    (byte_vld),
        .frame_pulse (frame_pulse)
    );

    AST_PULSE_WORD: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && byte_vld) |-> (byte_out == WORD_W'(SYNC_LO))); // R5
    AST_PULSE_NEEDS_HUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> $past(hunt)); // R7
endmodule

// File: tb/test_sonet_frame_aligner.sv
`timescale 1ns/1ps
module test_sonet_frame_aligner;
    localparam logic [47:0] PAT = 48'hF6F6F6282828;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       search_en = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       frame_pulse;

    int tests = 0;
    int fails = 0;
    int nstrobe = 0;
    logic       s_vld;
    logic       s_fp;
    logic [7:0] s_byte;

    always #2.5 clk = ~clk;

    sonet_frame_aligner i_sonet_frame_aligner (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .search_en(search_en), .byte_out(byte_out), .byte_vld(byte_vld),
        .frame_pulse(frame_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sample();
        s_vld  = byte_vld;
        s_fp   = frame_pulse;
        s_byte = byte_out;
        if (byte_vld) nstrobe++;
    endtask

    task automatic send_bit(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk);
        #2;
        bit_vld = 1'b0;
        sample();
    endtask

    task automatic idle();
        bit_vld = 1'b0;
        @(posedge clk);
        #2;
        sample();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        idle();
        rst = 1'b0;
    endtask

    task automatic send_pat();
        for (int i = 47; i >= 0; i--) send_bit(PAT[i]);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        do_reset();
        check(!byte_vld && !frame_pulse && byte_out == 8'h00, "R1 reset outputs",
              {byte_vld, frame_pulse, byte_out}, 0);

        // R3: HOLD after reset, pattern gives no pulse
        search_en = 1'b0;
        send_pat();
        check(!s_fp, "R3 no detect in HOLD", s_fp, 0);

        for (int off = 0; off < 8; off++) begin
            do_reset();
            search_en = 1'b1;
            idle();
            nstrobe = 0;
            for (int k = 0; k < off; k++) send_bit(1'b0);
            send_pat();
            check(s_vld && s_fp && s_byte == 8'h28, "R2 R5 pulse on third A2",
                  {s_vld, s_fp, s_byte}, {2'b11, 8'h28});
            check(nstrobe == (off + 47) / 8 + 1, "R4 single strobe at realign",
                  nstrobe, (off + 47) / 8 + 1);
            for (int k = 0; k < 3; k++) begin
                d = 8'h35 + 8'(off * 8) + 8'(k * 3);
                for (int b = 7; b >= 0; b--) begin
                    send_bit(d[b]);
                    if (k == 0 && b == 7)
                        check(s_fp && !s_vld, "R6 pulse held between strobes", {s_fp, s_vld}, 2'b10);
                    if (k == 1 && b == 4) begin
                        for (int w = 0; w < 3; w++) begin
                            idle();
                            check(!s_vld, "R8 stall no strobe", s_vld, 0);
                        end
                    end
                end
                check(s_vld && !s_fp && s_byte == d, "R9 R4 aligned word MSB first",
                      {s_vld, s_fp, s_byte}, {2'b10, d});
            end
            // R5: later detection at a new offset fires again
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
            send_pat();
            check(s_vld && s_fp && s_byte == 8'h28, "R5 repeat pulse",
                  {s_vld, s_fp, s_byte}, {2'b11, 8'h28});
            // R7: search off, boundary held
            search_en = 1'b0;
            idle();
            for (int k = 0; k < 5; k++) send_bit(1'b0);
            send_pat();
            check(!s_vld && !s_fp, "R7 no pulse in HOLD", {s_vld, s_fp}, 0);
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
            check(s_vld && !s_fp && s_byte == 8'h45, "R7 boundary held",
                  {s_vld, s_fp, s_byte}, {2'b10, 8'h45});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule